// File: doc/BRIEF.md
# Receive Frame CRC Checker and Forwarder

This block sits between a receive deframer and a receive FIFO. Deframed frame bytes arrive one per handshake, with the last byte of each frame marked. An abort strobe can end a frame early. The block runs a CRC over the frame and holds back the trailing check bytes in a short delay line. It writes the payload bytes to the FIFO side and closes every frame with a single status byte. That status byte reports whether the CRC matched, whether the frame was long enough to count as valid, and whether the frame was aborted.

A 16-bit or a 32-bit check sequence can be selected. A forwarding control decides whether the received check bytes are dropped or written to the FIFO just ahead of the status byte. The check is made in both cases. Forwarding takes effect only in two of the four receive modes. In one of those two modes it also lowers the minimum length that a valid frame needs.

The FIFO side is a valid/ready interface. When the FIFO is full, the block stalls its input through its own ready signal, so no byte is lost.

Top module: `rx_crc_fwd`

## Requirements
- R1: After reset, `out_valid_o` is low and `in_ready_o` is high.
- R2: All frame bytes except the trailing check bytes (2 bytes for CRC-16, 4 bytes for CRC-32) appear at the output in their arrival order, each exactly once, with `out_status_o` low.
- R3: The check register is preset to all ones and takes each byte LSB first. For each bit, the feedback is the register MSB XOR the data bit; the register shifts left, and the polynomial is XORed in when the feedback is 1. The polynomial is 0x1021 for CRC-16 and 0x04C11DB7 for CRC-32, selected by `cfg_crc32_i`. The expected check byte k (k=0 received first) is the complement of register bits [8k+7:8k] after the payload. Status bit 0 is 1 only if every trailing byte matches.
- R4: When `cfg_fwd_crc_i`=1 and `cfg_mode_i` is 1 or 2, the trailing check bytes follow the payload at the output in arrival order, with `out_status_o` low, immediately before the status byte.
- R5: When `cfg_mode_i` is 0 or 3, `cfg_fwd_crc_i` has no effect: no check bytes reach the output.
- R6: Each frame ends with exactly one status byte, flagged by `out_status_o`=1. Bit 0 is CRC ok, bit 1 is valid frame, bit 2 is aborted, and bits 7:3 are zero.
- R7: Status bit 1 is 1 when the frame was not aborted and its total length is at least the check length plus one. In mode 1 with `cfg_fwd_crc_i`=1, the limit drops to the check length itself.
- R8: A handshake with `in_abort_i`=1 ends the frame. The byte on `in_data_i` in that handshake and the held-back bytes are discarded, and the status byte is 0x04.
- R9: While `out_valid_o`=1 and `out_ready_i`=0, the output holds its byte and flag, and `in_ready_o` is low.
- R10: A frame shorter than the check length reports CRC ok 0 and valid 0 and produces no payload bytes. Its bytes are output only when forwarding is in effect.
- R11: After the closing byte of a frame is accepted, `in_ready_o` stays low until that frame's status byte has been handed over.
- R12: The configuration inputs must be held stable from a frame's first byte until its status byte is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_mode_i | input | 2 | Receive mode: 0 addressed, 1 non-addressed, 2 transparent A, 3 transparent B |
| cfg_crc32_i | input | 1 | 1 selects a 32-bit check, 0 a 16-bit check |
| cfg_fwd_crc_i | input | 1 | Request to pass the received check bytes to the output |
| in_data_i | input | 8 | Received frame byte |
| in_valid_i | input | 1 | Input byte or abort present |
| in_eof_i | input | 1 | Byte is the last of its frame |
| in_abort_i | input | 1 | Frame aborted; the byte is ignored |
| in_ready_o | output | 1 | Input handshake accepted this cycle |
| out_data_o | output | 8 | Byte toward the FIFO |
| out_status_o | output | 1 | Output byte is the frame status byte |
| out_valid_o | output | 1 | Output byte present |
| out_ready_i | input | 1 | FIFO can take the byte |

## Verification
The bench goes after the frames whose length sits at the check-length boundary. A zero-payload frame tests the lowered limit: if the limit were applied in the wrong mode, or not lowered at all, the valid bit would flip. A frame with a single byte tests the short case: if the short frame were not handled, a held byte would leak out as data, or the CRC would be reported good. Forwarding is also requested in a mode that forbids it; a design that ignored the mode gate would emit check bytes ahead of the status. Aborts come after the delay line is full, so a design that failed to flush the delay line would emit stale bytes. Random output stalls test the path under back-pressure: if the design dropped a byte or duplicated one there, the expected byte order would break.

// File: rtl/rxcrc_pkg.sv
package rxcrc_pkg;
  typedef enum logic [1:0] {
    MODE_ADDR     = 2'd0,
    MODE_NOADDR   = 2'd1,
    MODE_TRANSP_A = 2'd2,
    MODE_TRANSP_B = 2'd3
  } rx_mode_e;

  typedef enum logic [1:0] {
    PH_RUN  = 2'd0,
    PH_CHK  = 2'd1,
    PH_TAIL = 2'd2,
    PH_STAT = 2'd3
  } rx_phase_e;

  localparam int STAT_CRC_OK = 0;
  localparam int STAT_VALID  = 1;
  localparam int STAT_ABORT  = 2;
  localparam int STAT_W      = 3;
endpackage

// File: rtl/rxcrc_crc_unit.sv
module rxcrc_crc_unit #(
  parameter int           W    = 16,
  parameter logic [W-1:0] POLY = W'('h1021),
  parameter logic [W-1:0] INIT = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         en_i,
  input  logic [7:0]   data_i,
  output logic [W-1:0] crc_o
);
  logic [W-1:0] crc_q;

  function automatic logic [W-1:0] step(logic [W-1:0] c, logic [7:0] d);
    logic fb;
    for (int i = 0; i < 8; i++) begin
      fb = c[W-1] ^ d[i];
      c  = {c[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    return c;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= INIT;
    else if (clear_i) crc_q <= INIT;
    else if (en_i)    crc_q <= step(crc_q, data_i);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/rxcrc_delay_line.sv
module rxcrc_delay_line #(
  parameter  int DEPTH = 4,
  parameter  int W     = 8,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [W-1:0]     data_i,
  input  logic [CW-1:0]    limit_i,
  output logic [W-1:0]     head_o,
  output logic [CW-1:0]    cnt_o,
  output logic             full_o,
  output logic [DEPTH*W-1:0] flat_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [W-1:0]  mem_n [DEPTH];
  logic [CW-1:0] cnt_q, cnt_n, wp;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) mem_n[i] = mem_q[i];
    if (pop_i) begin
      for (int i = 0; i < DEPTH - 1; i++) mem_n[i] = mem_q[i+1];
      mem_n[DEPTH-1] = '0;
    end
    wp = pop_i ? cnt_q - CW'(1) : cnt_q;
    for (int i = 0; i < DEPTH; i++)
      if (push_i && CW'(i) == wp) mem_n[i] = data_i;
    cnt_n = cnt_q + CW'(push_i) - CW'(pop_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_n;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_n[i];
    end
  end

  assign head_o = mem_q[0];
  assign cnt_o  = cnt_q;
  assign full_o = (cnt_q == limit_i);

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign flat_o[g*W +: W] = mem_q[g];
  end
endmodule

// File: rtl/rxcrc_fcs_match.sv
module rxcrc_fcs_match #(
  parameter  int NB  = 4,
  localparam int NBW = $clog2(NB + 1)
) (
  input  logic [NB*8-1:0] rx_i,
  input  logic [NB*8-1:0] crc_i,
  input  logic [NBW-1:0]  nb_i,
  output logic            match_o
);
  logic [NB-1:0] eq;

  for (genvar k = 0; k < NB; k++) begin : g_byte
    assign eq[k] = (rx_i[k*8 +: 8] == ~crc_i[k*8 +: 8]) || (k >= int'(nb_i));
  end

  assign match_o = &eq;
endmodule

// File: rtl/rx_crc_fwd.sv
module rx_crc_fwd
  import rxcrc_pkg::*;
#(
  parameter logic [15:0] POLY16 = 16'h1021,
  parameter logic [15:0] INIT16 = 16'hFFFF,
  parameter logic [31:0] POLY32 = 32'h04C1_1DB7,
  parameter logic [31:0] INIT32 = 32'hFFFF_FFFF,
  parameter int          LEN_W  = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] cfg_mode_i,
  input  logic       cfg_crc32_i,
  input  logic       cfg_fwd_crc_i,
  input  logic [7:0] in_data_i,
  input  logic       in_valid_i,
  input  logic       in_eof_i,
  input  logic       in_abort_i,
  output logic       in_ready_o,
  output logic [7:0] out_data_o,
  output logic       out_status_o,
  output logic       out_valid_o,
  input  logic       out_ready_i
);
  localparam int FCS_S = 16 / 8;
  localparam int FCS_L = 32 / 8;
  localparam int CW    = $clog2(FCS_L + 1);

  rx_phase_e ph_q;
  logic [STAT_W-1:0] status_q;
  logic [LEN_W-1:0]  len_q, min_len;
  logic [CW-1:0]     fcs_len, dl_cnt;
  logic [7:0]        dl_head;
  logic [FCS_L*8-1:0] dl_flat;
  logic [15:0]       crc16;
  logic [31:0]       crc32, crc_sel;
  logic fwd_eff, slot_free, acc, acc_byte, acc_abort;
  logic dl_full, pop_run, pop_tail, dl_clear, crc_clear, fcs_ok, stat_go;
  logic ov_q, os_q;
  logic [7:0] od_q;

  // Forwarding only honoured in non-addressed or transparent-A mode
  assign fwd_eff   = cfg_fwd_crc_i &&
                     (cfg_mode_i == MODE_NOADDR || cfg_mode_i == MODE_TRANSP_A);
  assign fcs_len   = cfg_crc32_i ? CW'(FCS_L) : CW'(FCS_S);
  assign min_len   = (fwd_eff && cfg_mode_i == MODE_NOADDR) ? LEN_W'(fcs_len)
                                                             : LEN_W'(fcs_len) + LEN_W'(1);

  assign slot_free  = !ov_q || out_ready_i;
  assign in_ready_o = (ph_q == PH_RUN) && slot_free;
  assign acc        = in_valid_i && in_ready_o;
  assign acc_byte   = acc && !in_abort_i;
  assign acc_abort  = acc && in_abort_i;
  assign pop_run    = acc_byte && dl_full;
  assign pop_tail   = (ph_q == PH_TAIL) && slot_free;
  assign stat_go    = (ph_q == PH_STAT) && slot_free;
  assign dl_clear   = acc_abort || stat_go || (ph_q == PH_CHK && !fwd_eff);
  assign crc_clear  = acc_abort || stat_go;

  rxcrc_delay_line #(.DEPTH(FCS_L), .W(8)) u_dly (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (dl_clear),
    .push_i  (acc_byte),
    .pop_i   (pop_run || pop_tail),
    .data_i  (in_data_i),
    .limit_i (fcs_len),
    .head_o  (dl_head),
    .cnt_o   (dl_cnt),
    .full_o  (dl_full),
    .flat_o  (dl_flat)
  );

  rxcrc_crc_unit #(.W(16), .POLY(POLY16), .INIT(INIT16)) u_crc16 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (crc_clear),
    .en_i    (pop_run),
    .data_i  (dl_head),
    .crc_o   (crc16)
  );

  rxcrc_crc_unit #(.W(32), .POLY(POLY32), .INIT(INIT32)) u_crc32 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (crc_clear),
    .en_i    (pop_run),
    .data_i  (dl_head),
    .crc_o   (crc32)
  );

  assign crc_sel = cfg_crc32_i ? crc32 : {16'h0000, crc16};

  rxcrc_fcs_match #(.NB(FCS_L)) u_match (
    .rx_i    (dl_flat),
    .crc_i   (crc_sel),
    .nb_i    (fcs_len),
    .match_o (fcs_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q     <= PH_RUN;
      status_q <= '0;
      len_q    <= '0;
    end else begin
      if (crc_clear)                     len_q <= '0;
      else if (acc_byte && len_q != '1)  len_q <= len_q + LEN_W'(1);
      unique case (ph_q)
        PH_RUN: begin
          if (acc_abort) begin
            status_q              <= '0;
            status_q[STAT_ABORT]  <= 1'b1;
            ph_q                  <= PH_STAT;
          end else if (acc_byte && in_eof_i) begin
            ph_q <= PH_CHK;
          end
        end
        PH_CHK: begin
          status_q[STAT_ABORT]  <= 1'b0;
          status_q[STAT_VALID]  <= (len_q >= min_len);
          status_q[STAT_CRC_OK] <= (dl_cnt == fcs_len) && fcs_ok;
          ph_q <= (fwd_eff && dl_cnt != '0) ? PH_TAIL : PH_STAT;
        end
        PH_TAIL: if (slot_free && dl_cnt == CW'(1)) ph_q <= PH_STAT;
        PH_STAT: if (slot_free) ph_q <= PH_RUN;
        default: ph_q <= PH_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ov_q <= 1'b0;
      od_q <= '0;
      os_q <= 1'b0;
    end else if (pop_run || pop_tail) begin
      ov_q <= 1'b1;
      od_q <= dl_head;
      os_q <= 1'b0;
    end else if (stat_go) begin
      ov_q <= 1'b1;
      od_q <= {{(8-STAT_W){1'b0}}, status_q};
      os_q <= 1'b1;
    end else if (out_ready_i) begin
      ov_q <= 1'b0;
    end
  end

  assign out_valid_o  = ov_q;
  assign out_data_o   = od_q;
  assign out_status_o = os_q;
endmodule

// File: rtl/rx_crc_fwd_chk.sv
module rx_crc_fwd_chk #(
  parameter int CW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          in_valid_i,
  input logic          in_eof_i,
  input logic          in_abort_i,
  input logic          in_ready_o,
  input logic [7:0]    out_data_o,
  input logic          out_status_o,
  input logic          out_valid_o,
  input logic          out_ready_i,
  input logic [CW-1:0] dl_cnt,
  input logic [CW-1:0] fcs_len
);
  a_r9_hold_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_status_o));

  a_r9_no_take_when_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in_ready_o);

  a_r6_status_top_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_status_o |-> out_data_o[7:3] == 5'd0);

  a_r8_abort_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_status_o && out_data_o[2] |-> out_data_o[1:0] == 2'b00);

  a_r11_closed_after_eof: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && in_eof_i && !in_abort_i |=> !in_ready_o);

  a_r2_holdback_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dl_cnt <= fcs_len);
endmodule

bind rx_crc_fwd rx_crc_fwd_chk #(.CW(3)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .in_valid_i   (in_valid_i),
  .in_eof_i     (in_eof_i),
  .in_abort_i   (in_abort_i),
  .in_ready_o   (in_ready_o),
  .out_data_o   (out_data_o),
  .out_status_o (out_status_o),
  .out_valid_o  (out_valid_o),
  .out_ready_i  (out_ready_i),
  .dl_cnt       (dl_cnt),
  .fcs_len      (fcs_len)
);

// File: tb/rx_crc_fwd_tb_top.sv
module rx_crc_fwd_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 60000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cfg_mode = 2'd0;
  logic cfg_crc32 = 1'b0, cfg_fwd = 1'b0;
  logic [7:0] in_data = '0;
  logic in_valid = 1'b0, in_eof = 1'b0, in_abort = 1'b0, in_ready;
  logic [7:0] out_data;
  logic out_status, out_valid, out_ready = 1'b1;

  int checks = 0, errors = 0;
  bit bp_on = 1'b0;
  logic [7:0] fr[$];
  logic [7:0] exp_d[$];
  bit exp_s[$];
  string exp_t[$];

  rx_crc_fwd dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_mode_i(cfg_mode), .cfg_crc32_i(cfg_crc32), .cfg_fwd_crc_i(cfg_fwd),
    .in_data_i(in_data), .in_valid_i(in_valid), .in_eof_i(in_eof),
    .in_abort_i(in_abort), .in_ready_o(in_ready),
    .out_data_o(out_data), .out_status_o(out_status),
    .out_valid_o(out_valid), .out_ready_i(out_ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // output side: drive ready, compare every handshake against the model queue
  bit stall_prev = 1'b0;
  logic [8:0] stall_v = '0;
  always @(negedge clk) begin
    out_ready = bp_on ? ($urandom % 3 != 0) : 1'b1;
    #2;
    if (rst_n) begin
      if (stall_prev)
        check(out_valid && {out_status, out_data} == stall_v, "R9", "stalled output changed",
              {out_valid, out_status, out_data}, {1'b1, stall_v});
      if (out_valid && out_ready) begin
        if (exp_d.size() == 0) begin
          check(1'b0, "R2", "unexpected output byte", {out_status, out_data}, 0);
        end else begin
          logic [7:0] ed;
          bit es;
          string et;
          ed = exp_d.pop_front();
          es = exp_s.pop_front();
          et = exp_t.pop_front();
          check({out_status, out_data} == {es, ed}, et, "output byte",
                {out_status, out_data}, {es, ed});
        end
      end
      stall_prev = out_valid && !out_ready;
      stall_v    = {out_status, out_data};
    end
  end

  function automatic logic [31:0] crc_calc(int n, bit c32);
    logic [31:0] c, poly, mask;
    int w;
    logic fb;
    w    = c32 ? 32 : 16;
    mask = c32 ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    poly = c32 ? 32'h04C1_1DB7 : 32'h0000_1021;
    c    = mask;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++) begin
        fb = c[w-1] ^ fr[i][b];
        c  = (c << 1) & mask;
        if (fb) c = c ^ poly;
      end
    return c;
  endfunction

  task automatic build(int npay, int seed, bit c32, bit corrupt);
    logic [31:0] c;
    int nl;
    nl = c32 ? 4 : 2;
    fr.delete();
    for (int i = 0; i < npay; i++) fr.push_back(8'(seed * 31 + i * 7 + 3));
    c = crc_calc(npay, c32);
    for (int k = 0; k < nl; k++) fr.push_back(~c[8*k +: 8]);
    if (corrupt) fr[fr.size()-1] = fr[fr.size()-1] ^ 8'h40;
  endtask

  task automatic build_raw(int n, int seed);
    fr.delete();
    for (int i = 0; i < n; i++) fr.push_back(8'(seed * 13 + i * 5 + 1));
  endtask

  task automatic expect_frame(bit c32, bit fwd, logic [1:0] mode, string tag);
    int n, nl, nd, minl;
    bit fe, ok, vld;
    logic [31:0] c;
    n  = fr.size();
    nl = c32 ? 4 : 2;
    fe = fwd && (mode == 2'd1 || mode == 2'd2);
    nd = (n > nl) ? n - nl : 0;
    for (int i = 0; i < nd; i++) begin
      exp_d.push_back(fr[i]); exp_s.push_back(1'b0); exp_t.push_back("R2");
    end
    if (fe)
      for (int i = nd; i < n; i++) begin
        exp_d.push_back(fr[i]); exp_s.push_back(1'b0); exp_t.push_back("R4");
      end
    ok = (n >= nl);
    if (ok) begin
      c = crc_calc(n - nl, c32);
      for (int k = 0; k < nl; k++) if (fr[n-nl+k] != ~c[8*k +: 8]) ok = 1'b0;
    end
    minl = (fe && mode == 2'd1) ? nl : nl + 1;
    vld  = (n >= minl);
    exp_d.push_back({6'd0, vld, ok}); exp_s.push_back(1'b1); exp_t.push_back(tag);
  endtask

  task automatic send_byte(logic [7:0] d, bit eof, bit abt);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_eof = eof; in_abort = abt;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0; in_eof = 1'b0; in_abort = 1'b0;
  endtask

  task automatic drain();
    while (exp_d.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic set_cfg(bit c32, bit fwd, logic [1:0] mode);
    drain();
    cfg_crc32 = c32; cfg_fwd = fwd; cfg_mode = mode;   // R12: only between frames
  endtask

  task automatic run_frame(bit c32, bit fwd, logic [1:0] mode, string tag);
    set_cfg(c32, fwd, mode);
    expect_frame(c32, fwd, mode, tag);
    for (int i = 0; i < fr.size(); i++) send_byte(fr[i], i == fr.size() - 1, 1'b0);
    @(negedge clk);
    #1;
    check(!in_ready, "R11", "input open right after closing byte", in_ready, 0);
  endtask

  task automatic run_abort(bit c32, int n, int seed);
    int nl;
    nl = c32 ? 4 : 2;
    set_cfg(c32, 1'b1, 2'd2);
    build_raw(n, seed);
    for (int i = 0; i < n - nl; i++) begin
      exp_d.push_back(fr[i]); exp_s.push_back(1'b0); exp_t.push_back("R8");
    end
    exp_d.push_back(8'h04); exp_s.push_back(1'b1); exp_t.push_back("R8");
    for (int i = 0; i < n; i++) send_byte(fr[i], 1'b0, 1'b0);
    send_byte(8'hA5, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    check(1'b0, "R9", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check(!out_valid, "R1", "out_valid after reset", out_valid, 0);
    check(in_ready, "R1", "in_ready during reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(!out_valid && in_ready, "R1", "idle state after reset", {out_valid, in_ready}, 1);

    build(6, 1, 1'b0, 1'b0); run_frame(1'b0, 1'b0, 2'd1, "R3");   // R2 R3 CRC-16 good
    build(9, 2, 1'b1, 1'b0); run_frame(1'b1, 1'b0, 2'd0, "R3");   // CRC-32 good
    build(5, 3, 1'b0, 1'b1); run_frame(1'b0, 1'b0, 2'd0, "R3");   // corrupted check byte
    build(4, 4, 1'b1, 1'b1); run_frame(1'b1, 1'b0, 2'd2, "R3");
    build(7, 5, 1'b1, 1'b0); run_frame(1'b1, 1'b1, 2'd2, "R4");   // forwarded
    build(3, 6, 1'b0, 1'b0); run_frame(1'b0, 1'b1, 2'd1, "R4");
    build(5, 7, 1'b0, 1'b0); run_frame(1'b0, 1'b1, 2'd3, "R5");   // request ignored
    build(5, 8, 1'b1, 1'b0); run_frame(1'b1, 1'b1, 2'd0, "R5");
    build(0, 9, 1'b0, 1'b0); run_frame(1'b0, 1'b1, 2'd1, "R7");   // limit lowered
    build(0, 9, 1'b0, 1'b0); run_frame(1'b0, 1'b0, 2'd1, "R7");
    build(0, 9, 1'b1, 1'b0); run_frame(1'b1, 1'b1, 2'd2, "R7");
    build(1, 10, 1'b0, 1'b0); run_frame(1'b0, 1'b0, 2'd1, "R7");
    build_raw(1, 11); run_frame(1'b1, 1'b1, 2'd2, "R10");          // short, forwarded
    build_raw(3, 12); run_frame(1'b1, 1'b0, 2'd0, "R10");
    build_raw(1, 13); run_frame(1'b0, 1'b0, 2'd1, "R10");
    run_abort(1'b0, 5, 14);                                        // R8
    run_abort(1'b1, 7, 15);
    run_abort(1'b1, 2, 16);
    run_abort(1'b0, 0, 17);
    bp_on = 1'b1;                                                  // R9 back-pressure
    for (int f = 0; f < 12; f++) begin
      build(f + 1, 20 + f, f[0], f % 5 == 3);
      run_frame(f[0], f[1], 2'(f % 4), "R9");
    end
    run_abort(1'b1, 9, 40);
    build(6, 41, 1'b0, 1'b0); run_frame(1'b0, 1'b1, 2'd1, "R9");
    drain();
    bp_on = 1'b0;
    repeat (5) @(negedge clk);
    check(exp_d.size() == 0, "R6", "status bytes missing", exp_d.size(), 0);
    check(!out_valid, "R6", "extra output after last status", out_valid, 0);
    finish_run();
  end
endmodule